// File: doc/BRIEF.md
# Configurable SAD Block Matcher

This block finds the motion vector of a square pixel block. It scores candidate displacements of a reference block against the current block by the sum of absolute differences (SAD). Sixteen lanes each take one current pixel and one reference pixel per cycle and produce an absolute difference. An adder tree reduces the sixteen lanes to a row sum, and an accumulator adds sixteen row sums into the score of one candidate.

A controller decides which candidate is scored next and which block row is needed. It publishes each request on the `req_*` outputs. The surrounding pixel store must answer in the same cycle on `cur_row` and `ref_row`. Two search modes share the datapath. Full search visits every displacement of a window with unit step. Three-step search scans a 3x3 grid whose step halves from 8 down to 1, and recentres on the best point after each pass. Window bounds and grid points are formed with additions and shifts only.

After the last candidate, the block raises `done` for one cycle. The best vector and its SAD are valid in that cycle and stay unchanged until the next start.

Top module: `sad_block_matcher`

## Requirements
- R1: Lane k carries bits [8k+7:8k] of `cur_row` and `ref_row` as unsigned 8-bit pixels. The SAD of a candidate is the sum of |cur-ref| over 16 lanes and block rows 0 to 15. The accumulator restarts at row 0, so no earlier candidate leaks in.
- R2: Each scored candidate occupies exactly 16 consecutive cycles. In those cycles `req_valid` is high, `req_row` steps 0,1,...,15, and `req_mv_x`/`req_mv_y` stay constant.
- R3: With `mode`=0 (full search), the window is [max(c-r,-15), min(c+r,15)] on each axis, where c is the center and r is the range. Every point of the window is visited with step 1. The y coordinate is the outer loop and x the inner loop, both ascending.
- R4: With `mode`=1 (three-step search), four passes use steps 8, 4, 2 and 1. Each pass visits the points c+{-s,0,+s} on each axis, in y-outer, x-inner ascending order. The first pass is centred on the start center, and each later pass on the best vector so far.
- R5: In three-step search, a grid point with either coordinate outside [-r,+r] is never requested and takes no part in the result.
- R6: The best register is replaced only by a strictly smaller SAD. When SADs are equal, the earliest visited candidate wins.
- R7: `done` is high for exactly one cycle. `best_mv_x`, `best_mv_y` and `best_sad` are final in that cycle and hold until the next accepted start.
- R8: After reset, `req_valid` and `done` are low and `best_sad` is 0xFFFF.
- R9: If no candidate is scored, the result is the start center with SAD 0xFFFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Begins a search when the block is idle |
| mode | input | 1 | 0 = full search, 1 = three-step search |
| center_x | input | 6 | Search center x, two's complement, within ±15 |
| center_y | input | 6 | Search center y, two's complement, within ±15 |
| search_range | input | 5 | Range r, 0 to 15 |
| cur_row | input | 128 | Current block row for `req_row` |
| ref_row | input | 128 | Reference row at displacement `req_mv_*`, row `req_row` |
| req_valid | output | 1 | Row request is active |
| req_mv_x | output | 6 | Requested candidate x displacement |
| req_mv_y | output | 6 | Requested candidate y displacement |
| req_row | output | 4 | Requested block row |
| done | output | 1 | One-cycle end-of-search pulse |
| best_mv_x | output | 6 | Best displacement x |
| best_mv_y | output | 6 | Best displacement y |
| best_sad | output | 16 | SAD of the best displacement |

## Verification
The bench uses the default parameters: 16 lanes, 8-bit pixels, a displacement limit of 15 and four three-step passes. With these values, clipping at ±15, the full 8-4-2-1 step sequence and the maximal SAD sentinel can all be reached. Full-search ranges of 3 keep scans short while still hitting the clipped corner of the window. Three-step runs with ranges of 15, 4 and 2 cover the unclipped grid, passes whose outer points are skipped, and a search in which every point is skipped. Flat frames force ties, and textured frames give a single clear minimum.

// File: rtl/sbm_pkg.sv
// Shared types for the SAD block matcher.
// Assumes: nothing beyond IEEE 1800-2017.
package sbm_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETUP,
        ST_SCAN,
        ST_DRAIN,
        ST_DONE
    } ctrl_state_t;

    localparam logic MODE_FULL = 1'b0;
    localparam logic MODE_TSS  = 1'b1;
endpackage

// File: rtl/sbm_pe_array.sv
// Lane array plus adder tree: one row of |cur-ref| reduced to a row sum.
// Assumes: LANES is a power of two; purely combinational.
module sbm_pe_array #(
    parameter int LANES = 16,
    parameter int PIX_W = 8,
    parameter int SAD_W = 16
) (
    input  logic [LANES*PIX_W-1:0] cur_row,
    input  logic [LANES*PIX_W-1:0] ref_row,
    output logic [SAD_W-1:0]       row_sad
);
    localparam int LVLS = $clog2(LANES);

    for (genvar l = 0; l <= LVLS; l++) begin : g_lvl
        localparam int N = LANES >> l;
        logic [SAD_W-1:0] sum [N];
        if (l == 0) begin : g_leaf
            for (genvar k = 0; k < N; k++) begin : g_pe
                logic [PIX_W-1:0] c_px;
                logic [PIX_W-1:0] r_px;
                assign c_px = cur_row[k*PIX_W +: PIX_W];
                assign r_px = ref_row[k*PIX_W +: PIX_W];
                // Absolute difference of one lane.
                assign sum[k] = (c_px > r_px) ? SAD_W'(c_px - r_px) : SAD_W'(r_px - c_px);
            end
        end else begin : g_node
            for (genvar k = 0; k < N; k++) begin : g_add
                // Pairwise reduction of the level below.
                assign sum[k] = g_lvl[l-1].sum[2*k] + g_lvl[l-1].sum[2*k+1];
            end
        end
    end

    assign row_sad = g_lvl[LVLS].sum[0];
endmodule

// File: rtl/sbm_accum.sv
// Row accumulator: adds LANES row sums into one candidate SAD.
// Assumes: rows of a candidate arrive in order 0..LANES-1 on consecutive cycles.
module sbm_accum #(
    parameter int LANES = 16,
    parameter int PIX_W = 8,
    parameter int SAD_W = 16,
    parameter int MV_W  = 6
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   row_valid,
    input  logic [$clog2(LANES)-1:0] row_idx,
    input  logic [SAD_W-1:0]       row_sad,
    input  logic [MV_W-1:0]        mv_x,
    input  logic [MV_W-1:0]        mv_y,
    output logic                   cand_valid,
    output logic [SAD_W-1:0]       cand_sad,
    output logic [MV_W-1:0]        cand_x,
    output logic [MV_W-1:0]        cand_y
);
    localparam int ROW_W = $clog2(LANES);
    localparam logic [ROW_W-1:0] LAST_ROW = ROW_W'(LANES - 1);
    localparam logic [SAD_W-1:0] SAD_CEIL = SAD_W'(LANES * LANES * ((1 << PIX_W) - 1));

    logic [SAD_W-1:0] acc_q;
    logic [SAD_W-1:0] acc_next;

    // Restart on row 0, otherwise extend the running sum.
    assign acc_next = (row_idx == '0) ? row_sad : acc_q + row_sad;

    // Register running sum and publish a finished candidate.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q      <= '0;
            cand_valid <= 1'b0;
            cand_sad   <= '0;
            cand_x     <= '0;
            cand_y     <= '0;
        end else begin
            cand_valid <= row_valid && (row_idx == LAST_ROW);
            if (row_valid) begin
                acc_q <= acc_next;
                if (row_idx == LAST_ROW) begin
                    cand_sad <= acc_next;
                    cand_x   <= mv_x;
                    cand_y   <= mv_y;
                end
            end
        end
    end

    AST_CAND_FROM_LAST_ROW: assert property (@(posedge clk) disable iff (!rst_n)
        cand_valid |-> ($past(row_valid) && $past(row_idx) == LAST_ROW)); // R2
    AST_SAD_CEIL: assert property (@(posedge clk) disable iff (!rst_n)
        cand_valid |-> cand_sad <= SAD_CEIL); // R1
endmodule

// File: rtl/sbm_best.sv
// Best-match register: keeps the smallest SAD seen and its vector.
// Assumes: load has priority; ties never replace the stored entry.
module sbm_best #(
    parameter int SAD_W = 16,
    parameter int MV_W  = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [MV_W-1:0]  init_x,
    input  logic [MV_W-1:0]  init_y,
    input  logic             cand_valid,
    input  logic [SAD_W-1:0] cand_sad,
    input  logic [MV_W-1:0]  cand_x,
    input  logic [MV_W-1:0]  cand_y,
    output logic [SAD_W-1:0] best_sad,
    output logic [MV_W-1:0]  best_x,
    output logic [MV_W-1:0]  best_y
);
    // Seed on load, then take only strictly smaller scores.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            best_sad <= '1;
            best_x   <= '0;
            best_y   <= '0;
        end else if (load) begin
            best_sad <= '1;
            best_x   <= init_x;
            best_y   <= init_y;
        end else if (cand_valid && (cand_sad < best_sad)) begin
            best_sad <= cand_sad;
            best_x   <= cand_x;
            best_y   <= cand_y;
        end
    end

    AST_BEST_NO_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> best_sad <= $past(best_sad)); // R6
    AST_BEST_TAKES_SMALLER: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && cand_valid && cand_sad < best_sad) |=> best_sad == $past(cand_sad)); // R6
endmodule

// File: rtl/sbm_ctrl.sv
// Search controller: forms the window per pass, walks grid points,
// skips points outside the window and issues one row request per cycle.
// Assumes: center within +-MV_LIMIT, range <= MV_LIMIT, MV_W holds 2*MV_LIMIT+1.
module sbm_ctrl
    import sbm_pkg::*;
#(
    parameter int LANES     = 16,
    parameter int MV_W      = 6,
    parameter int RANGE_W   = 5,
    parameter int MV_LIMIT  = 15,
    parameter int TSS_ITERS = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     start,
    input  logic                     mode,
    input  logic signed [MV_W-1:0]   center_x,
    input  logic signed [MV_W-1:0]   center_y,
    input  logic [RANGE_W-1:0]       range_i,
    input  logic signed [MV_W-1:0]   best_x,
    input  logic signed [MV_W-1:0]   best_y,
    output logic                     req_valid,
    output logic signed [MV_W-1:0]   req_x,
    output logic signed [MV_W-1:0]   req_y,
    output logic [$clog2(LANES)-1:0] req_row,
    output logic                     load_best,
    output logic                     done
);
    localparam int ROW_W = $clog2(LANES);
    localparam int IT_W  = (TSS_ITERS > 1) ? $clog2(TSS_ITERS) : 1;
    localparam int FIRST_STEP = 1 << (TSS_ITERS - 1);
    localparam logic signed [MV_W-1:0] LIM = MV_W'(MV_LIMIT);
    localparam logic [ROW_W-1:0] LAST_ROW = ROW_W'(LANES - 1);
    localparam logic [IT_W-1:0]  LAST_IT  = IT_W'(TSS_ITERS - 1);

    ctrl_state_t state_q;
    logic                   mode_q;
    logic [RANGE_W-1:0]     range_q;
    logic [IT_W-1:0]        iter_q;
    logic signed [MV_W-1:0] org_x_q, org_y_q;
    logic signed [MV_W-1:0] step_q;
    logic signed [MV_W-1:0] lo_x_q, hi_x_q, lo_y_q, hi_y_q;
    logic signed [MV_W-1:0] x_first_q, x_last_q, y_last_q;
    logic signed [MV_W-1:0] px_q, py_q;
    logic [ROW_W-1:0]       row_q;

    logic signed [MV_W-1:0] rng_s, ctr_x, ctr_y, step_n;
    logic signed [MV_W-1:0] fs_lo_x, fs_hi_x, fs_lo_y, fs_hi_y;
    logic signed [MV_W-1:0] lo_x_n, hi_x_n, lo_y_n, hi_y_n;
    logic signed [MV_W-1:0] first_x, last_x, first_y, last_y;
    logic signed [MV_W:0]   nx, ny, xl_ext, yl_ext;
    logic                   in_win, last_row;

    // Window and grid of the coming pass, from shifts and adds only.
    always_comb begin
        rng_s   = MV_W'(range_q);
        ctr_x   = (iter_q == '0) ? org_x_q : best_x;
        ctr_y   = (iter_q == '0) ? org_y_q : best_y;
        step_n  = (mode_q == MODE_FULL) ? MV_W'(1) : MV_W'(FIRST_STEP >> iter_q);
        fs_lo_x = (org_x_q - rng_s < -LIM) ? -LIM : org_x_q - rng_s;
        fs_hi_x = (org_x_q + rng_s > LIM)  ?  LIM : org_x_q + rng_s;
        fs_lo_y = (org_y_q - rng_s < -LIM) ? -LIM : org_y_q - rng_s;
        fs_hi_y = (org_y_q + rng_s > LIM)  ?  LIM : org_y_q + rng_s;
        if (mode_q == MODE_FULL) begin
            lo_x_n = fs_lo_x; hi_x_n = fs_hi_x;
            lo_y_n = fs_lo_y; hi_y_n = fs_hi_y;
            first_x = fs_lo_x; last_x = fs_hi_x;
            first_y = fs_lo_y; last_y = fs_hi_y;
        end else begin
            lo_x_n = -rng_s; hi_x_n = rng_s;
            lo_y_n = -rng_s; hi_y_n = rng_s;
            first_x = ctr_x - step_n; last_x = ctr_x + step_n;
            first_y = ctr_y - step_n; last_y = ctr_y + step_n;
        end
    end

    // Scan position checks with one guard bit against overflow.
    always_comb begin
        nx       = (MV_W+1)'(px_q) + (MV_W+1)'(step_q);
        ny       = (MV_W+1)'(py_q) + (MV_W+1)'(step_q);
        xl_ext   = (MV_W+1)'(x_last_q);
        yl_ext   = (MV_W+1)'(y_last_q);
        in_win   = (px_q >= lo_x_q) && (px_q <= hi_x_q) &&
                   (py_q >= lo_y_q) && (py_q <= hi_y_q);
        last_row = (row_q == LAST_ROW);
    end

    assign req_valid = (state_q == ST_SCAN) && in_win;
    assign req_x     = px_q;
    assign req_y     = py_q;
    assign req_row   = row_q;
    assign load_best = (state_q == ST_IDLE) && start;
    assign done      = (state_q == ST_DONE);

    // Pass sequencing and point-by-point walk.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            mode_q    <= MODE_FULL;
            range_q   <= '0;
            iter_q    <= '0;
            org_x_q   <= '0;
            org_y_q   <= '0;
            step_q    <= '0;
            lo_x_q    <= '0;
            hi_x_q    <= '0;
            lo_y_q    <= '0;
            hi_y_q    <= '0;
            x_first_q <= '0;
            x_last_q  <= '0;
            y_last_q  <= '0;
            px_q      <= '0;
            py_q      <= '0;
            row_q     <= '0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        mode_q  <= mode;
                        range_q <= range_i;
                        org_x_q <= center_x;
                        org_y_q <= center_y;
                        iter_q  <= '0;
                        state_q <= ST_SETUP;
                    end
                end
                ST_SETUP: begin
                    step_q    <= step_n;
                    lo_x_q    <= lo_x_n;
                    hi_x_q    <= hi_x_n;
                    lo_y_q    <= lo_y_n;
                    hi_y_q    <= hi_y_n;
                    x_first_q <= first_x;
                    x_last_q  <= last_x;
                    y_last_q  <= last_y;
                    px_q      <= first_x;
                    py_q      <= first_y;
                    row_q     <= '0;
                    state_q   <= ST_SCAN;
                end
                ST_SCAN: begin
                    if (in_win && !last_row) begin
                        row_q <= row_q + 1'b1;
                    end else begin
                        row_q <= '0;
                        if (nx > xl_ext) begin
                            px_q <= x_first_q;
                            if (ny > yl_ext) state_q <= ST_DRAIN;
                            else             py_q    <= py_q + step_q;
                        end else begin
                            px_q <= px_q + step_q;
                        end
                    end
                end
                ST_DRAIN: begin
                    if (mode_q == MODE_FULL || iter_q == LAST_IT) begin
                        state_q <= ST_DONE;
                    end else begin
                        iter_q  <= iter_q + 1'b1;
                        state_q <= ST_SETUP;
                    end
                end
                ST_DONE:  state_q <= ST_IDLE;
                default:  state_q <= ST_IDLE;
            endcase
        end
    end

    AST_ROW_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_row != LAST_ROW) |=> (req_valid && req_row == $past(req_row) + 1'b1)); // R2
    AST_MV_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_row != LAST_ROW) |=> ($stable(req_x) && $stable(req_y))); // R2
    AST_MV_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> (req_x >= -LIM && req_x <= LIM && req_y >= -LIM && req_y <= LIM)); // R3
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R7
endmodule

// File: rtl/sad_block_matcher.sv
// Top of the SAD block matcher: controller, lane array, accumulator, best register.
// Assumes: the pixel store answers a row request combinationally in the same cycle.
module sad_block_matcher #(
    parameter int LANES     = 16,
    parameter int PIX_W     = 8,
    parameter int MV_W      = 6,
    parameter int RANGE_W   = 5,
    parameter int MV_LIMIT  = 15,
    parameter int TSS_ITERS = 4,
    localparam int SAD_W    = PIX_W + 2 * $clog2(LANES),
    localparam int ROW_W    = $clog2(LANES)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   start,
    input  logic                   mode,
    input  logic [MV_W-1:0]        center_x,
    input  logic [MV_W-1:0]        center_y,
    input  logic [RANGE_W-1:0]     search_range,
    input  logic [LANES*PIX_W-1:0] cur_row,
    input  logic [LANES*PIX_W-1:0] ref_row,
    output logic                   req_valid,
    output logic [MV_W-1:0]        req_mv_x,
    output logic [MV_W-1:0]        req_mv_y,
    output logic [ROW_W-1:0]       req_row,
    output logic                   done,
    output logic [MV_W-1:0]        best_mv_x,
    output logic [MV_W-1:0]        best_mv_y,
    output logic [SAD_W-1:0]       best_sad
);
    logic             load_best;
    logic [SAD_W-1:0] row_sad;
    logic             cand_valid;
    logic [SAD_W-1:0] cand_sad;
    logic [MV_W-1:0]  cand_x, cand_y;

    sbm_ctrl #(
        .LANES(LANES), .MV_W(MV_W), .RANGE_W(RANGE_W),
        .MV_LIMIT(MV_LIMIT), .TSS_ITERS(TSS_ITERS)
    ) u_ctrl (
        .clk(clk), .rst_n(rst_n), .start(start), .mode(mode),
        .center_x(center_x), .center_y(center_y), .range_i(search_range),
        .best_x(best_mv_x), .best_y(best_mv_y),
        .req_valid(req_valid), .req_x(req_mv_x), .req_y(req_mv_y),
        .req_row(req_row), .load_best(load_best), .done(done)
    );

    sbm_pe_array #(.LANES(LANES), .PIX_W(PIX_W), .SAD_W(SAD_W)) u_pe (
        .cur_row(cur_row), .ref_row(ref_row), .row_sad(row_sad)
    );

    sbm_accum #(.LANES(LANES), .PIX_W(PIX_W), .SAD_W(SAD_W), .MV_W(MV_W)) u_acc (
        .clk(clk), .rst_n(rst_n), .row_valid(req_valid), .row_idx(req_row),
        .row_sad(row_sad), .mv_x(req_mv_x), .mv_y(req_mv_y),
        .cand_valid(cand_valid), .cand_sad(cand_sad),
        .cand_x(cand_x), .cand_y(cand_y)
    );

    sbm_best #(.SAD_W(SAD_W), .MV_W(MV_W)) u_best (
        .clk(clk), .rst_n(rst_n), .load(load_best),
        .init_x(center_x), .init_y(center_y),
        .cand_valid(cand_valid), .cand_sad(cand_sad),
        .cand_x(cand_x), .cand_y(cand_y),
        .best_sad(best_sad), .best_x(best_mv_x), .best_y(best_mv_y)
    );
endmodule

// File: tb/sad_block_matcher_tb.sv
module sad_block_matcher_tb;
    localparam int BASE = 40;
    localparam int MAXC = 128;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic         mode = 1'b0;
    logic [5:0]   center_x = '0, center_y = '0;
    logic [4:0]   search_range = '0;
    logic [127:0] cur_row, ref_row;
    logic         req_valid, done;
    logic [5:0]   req_mv_x, req_mv_y, best_mv_x, best_mv_y;
    logic [3:0]   req_row;
    logic [15:0]  best_sad;

    int checks = 0, fails = 0;
    bit flat = 1'b0;
    int tx = 0, ty = 0;

    int  exp_x [MAXC], exp_y [MAXC], exp_n, exp_bx, exp_by, exp_sad;
    int  obs_x [MAXC], obs_y [MAXC], obs_n;
    int  prot_err, done_cnt, cur_cx, cur_cy;
    bit  open_c;
    int  prev_row;
    bit  mon_en = 1'b0;

    always #2.5 clk = ~clk;

    sad_block_matcher u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .mode(mode),
        .center_x(center_x), .center_y(center_y), .search_range(search_range),
        .cur_row(cur_row), .ref_row(ref_row),
        .req_valid(req_valid), .req_mv_x(req_mv_x), .req_mv_y(req_mv_y),
        .req_row(req_row), .done(done),
        .best_mv_x(best_mv_x), .best_mv_y(best_mv_y), .best_sad(best_sad)
    );

    function automatic int ref_pix(int x, int y);
        if (flat) return 100;
        return (x * 29 + y * 53 + x * y * 3) % 256;
    endfunction

    function automatic int cur_pix(int x, int y);
        if (flat) return 100;
        return ref_pix(x + tx, y + ty);
    endfunction

    // Pixel store model: answers the row request in the same cycle (R1 lane order).
    always_comb begin
        for (int k = 0; k < 16; k++) begin
            ref_row[k*8 +: 8] = 8'(ref_pix(BASE + int'($signed(req_mv_x)) + k,
                                           BASE + int'($signed(req_mv_y)) + int'(req_row)));
            cur_row[k*8 +: 8] = 8'(cur_pix(BASE + k, BASE + int'(req_row)));
        end
    end

    function automatic int sad_at(int mx, int my);
        int s = 0;
        for (int r = 0; r < 16; r++)
            for (int k = 0; k < 16; k++) begin
                int d = cur_pix(BASE + k, BASE + r) - ref_pix(BASE + mx + k, BASE + my + r);
                s += (d < 0) ? -d : d;
            end
        return s;
    endfunction

    task automatic visit(int x, int y);
        int s = sad_at(x, y);
        if (exp_n < MAXC) begin exp_x[exp_n] = x; exp_y[exp_n] = y; end
        exp_n++;
        if (s < exp_sad) begin exp_sad = s; exp_bx = x; exp_by = y; end
    endtask

    // Independent search model following R3..R6 and R9.
    task automatic model(bit md, int cx, int cy, int r);
        exp_n = 0; exp_sad = 65535; exp_bx = cx; exp_by = cy;
        if (!md) begin
            int lx = (cx - r < -15) ? -15 : cx - r;
            int hx = (cx + r > 15) ? 15 : cx + r;
            int ly = (cy - r < -15) ? -15 : cy - r;
            int hy = (cy + r > 15) ? 15 : cy + r;
            for (int y = ly; y <= hy; y++)
                for (int x = lx; x <= hx; x++) visit(x, y);
        end else begin
            int ccx = cx, ccy = cy;
            for (int it = 0; it < 4; it++) begin
                int s = 8 >> it;
                if (it > 0) begin ccx = exp_bx; ccy = exp_by; end
                for (int y = ccy - s; y <= ccy + s; y += s)
                    for (int x = ccx - s; x <= ccx + s; x += s)
                        if (x >= -r && x <= r && y >= -r && y <= r) visit(x, y);
            end
        end
    endtask

    // Port monitor: records candidates and protocol breaks (R2).
    always @(negedge clk) begin
        if (rst_n && mon_en) begin
            if (req_valid) begin
                if (req_row == 4'd0) begin
                    if (open_c) prot_err++;
                    if (obs_n < MAXC) begin
                        obs_x[obs_n] = int'($signed(req_mv_x));
                        obs_y[obs_n] = int'($signed(req_mv_y));
                    end
                    obs_n++;
                    cur_cx = int'($signed(req_mv_x));
                    cur_cy = int'($signed(req_mv_y));
                end else if (!open_c || int'(req_row) != prev_row + 1 ||
                             int'($signed(req_mv_x)) != cur_cx ||
                             int'($signed(req_mv_y)) != cur_cy) begin
                    prot_err++;
                end
                open_c = (req_row != 4'd15);
                prev_row = int'(req_row);
            end else if (open_c) begin
                prot_err++;
                open_c = 1'b0;
            end
            if (done) done_cnt++;
        end
    end

    task automatic chk(bit ok, string req, string what, int act, int expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
        end
    endtask

    task automatic run_search(string tag, bit md, int cx, int cy, int r,
                              bit fl, int tx_i, int ty_i);
        int cyc = 0, bad = 0, gx, gy, gs;
        flat = fl; tx = tx_i; ty = ty_i;
        model(md, cx, cy, r);
        obs_n = 0; prot_err = 0; done_cnt = 0; open_c = 1'b0; prev_row = 0;
        mon_en = 1'b1;
        @(negedge clk);
        mode = md; center_x = 6'(cx); center_y = 6'(cy); search_range = 5'(r);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        while (!done && cyc < 20000) begin @(negedge clk); cyc++; end
        if (!done) begin
            chk(1'b0, tag, "search timed out", cyc, 20000);
            return;
        end
        gx = int'($signed(best_mv_x)); gy = int'($signed(best_mv_y)); gs = int'(best_sad);
        chk(gs == exp_sad, "R1", {tag, " best SAD"}, gs, exp_sad);
        chk(gx == exp_bx, tag, "best mv x", gx, exp_bx);
        chk(gy == exp_by, tag, "best mv y", gy, exp_by);
        chk(obs_n == exp_n, tag, "candidate count", obs_n, exp_n);
        for (int i = 0; i < obs_n && i < exp_n && i < MAXC; i++)
            if (obs_x[i] != exp_x[i] || obs_y[i] != exp_y[i]) bad++;
        chk(bad == 0, tag, "visit order mismatches", bad, 0);
        chk(prot_err == 0, "R2", {tag, " row protocol errors"}, prot_err, 0);
        repeat (3) @(negedge clk);
        chk(done_cnt == 1, "R7", {tag, " done pulse count"}, done_cnt, 1);
        chk(int'($signed(best_mv_x)) == gx && int'($signed(best_mv_y)) == gy &&
            int'(best_sad) == gs, "R7", {tag, " result held after done"}, int'(best_sad), gs);
        mon_en = 1'b0;
    endtask

    task automatic test_reset;
        repeat (3) @(negedge clk);
        chk(req_valid == 1'b0, "R8", "req_valid in reset", int'(req_valid), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(req_valid == 1'b0, "R8", "req_valid after reset", int'(req_valid), 0);
        chk(done == 1'b0, "R8", "done after reset", int'(done), 0);
        chk(best_sad == 16'hFFFF, "R8", "best_sad after reset", int'(best_sad), 65535);
    endtask

    task automatic test_full_textured;
        run_search("R3", 1'b0, 0, 0, 3, 1'b0, 2, -1);
        chk(exp_bx == 2 && exp_by == -1 && exp_sad == 0, "R1", "model minimum at true shift", exp_sad, 0);
    endtask

    task automatic test_full_clipped;
        run_search("R3", 1'b0, 14, -13, 3, 1'b0, 13, -12);
        chk(exp_n == 30, "R3", "clipped window size", exp_n, 30);
    endtask

    task automatic test_tss_wide;
        run_search("R4", 1'b1, 0, 0, 15, 1'b0, 5, -6);
    endtask

    task automatic test_tss_skip;
        run_search("R5", 1'b1, 0, 0, 4, 1'b0, 3, 2);
        for (int i = 0; i < obs_n && i < MAXC; i++)
            chk(obs_x[i] >= -4 && obs_x[i] <= 4 && obs_y[i] >= -4 && obs_y[i] <= 4,
                "R5", "requested point inside range", obs_x[i], 0);
    endtask

    task automatic test_ties;
        run_search("R6", 1'b0, 1, 1, 1, 1'b1, 0, 0);
        chk(int'($signed(best_mv_x)) == 0 && int'($signed(best_mv_y)) == 0, "R6",
            "full-search tie keeps first point", int'($signed(best_mv_x)), 0);
        run_search("R6", 1'b1, 0, 0, 15, 1'b1, 0, 0);
        chk(int'($signed(best_mv_x)) == -8 && int'($signed(best_mv_y)) == -8, "R6",
            "three-step tie keeps first point", int'($signed(best_mv_x)), -8);
    endtask

    task automatic test_none_scored;
        run_search("R9", 1'b1, 12, 12, 2, 1'b0, 0, 0);
        chk(obs_n == 0, "R9", "no requests issued", obs_n, 0);
        chk(best_sad == 16'hFFFF, "R9", "sentinel SAD", int'(best_sad), 65535);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        test_reset();
        test_full_textured();
        test_full_clipped();
        test_tss_wide();
        test_tss_skip();
        test_ties();
        test_none_scored();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule